// File: doc/BRIEF.md
# Watchdog Timer with Internal Reset Generation

This block is an 8-bit watchdog counter that counts on ticks from a power-of-two prescaler running off the peripheral clock. Software enables the counter, selects one of eight tick rates and reloads the count through a small synchronous register port. If software fails to reload the count, it wraps past 0xFF. The wrap latches a sticky overflow flag and, when reset generation is armed, drives an internal reset pulse of fixed length.

The status register holding the flag and the reset-arm bit is cleared only by the pin reset. The internal pulse returns the counter and the enable bit to their idle values but leaves the status register as it was, so software can read after restart whether the watchdog caused that restart. The flag can be cleared by software, which must write a 0 to it.

Register map on `reg_addr`: 0 is the control register (bit 5 enable, bits 4..3 fixed at 1, bits 2..0 rate code, bits 7..6 read 0). 1 is the counter. 2 is the status register (bit 7 overflow flag, bit 6 reset arm, bit 5 reads 0, bits 4..0 fixed at 1). Address 3 reads 0.

Top module: `wdog_timer`

## Requirements
- R1: After pin reset the control register reads 0x18, the counter reads 0x00, the status register reads 0x1F and `wdt_rst_o` is low.
- R2: While the enable bit (control bit 5) is 1 the counter advances by one on each prescaler tick. Writing it to 0 stops the counter and zeroes it from the next cycle on. Writes to the counter are ignored while it is disabled.
- R3: Rate codes 0 through 7 (control bits 2..0) space counter increments by 2, 64, 128, 512, 2048, 8192, 32768 and 131072 clock cycles.
- R4: A counter increment from 0xFF wraps it to 0x00 and sets the overflow flag (status bit 7) on the same clock edge.
- R5: A write of 0 to status bit 7 clears the flag. A write of 1 leaves it unchanged. When a clearing write and a wrap fall on the same edge, the flag ends up set.
- R6: A wrap with the reset-arm bit (status bit 6) at 1 drives `wdt_rst_o` high from that edge for exactly 16 cycles. With the bit at 0 the output stays low.
- R7: The internal reset pulse leaves the counter at 0 and the enable bit at 0, with control and counter writes ignored while the pulse lasts. It leaves the status register unchanged, so the register reads 0xDF after a pulse.
- R8: Control bits 4..3 and status bits 4..0 always read 1, and writes to them have no effect.
- R9: A counter write while the timer is enabled loads the written value. It overrides an increment on the same edge.
- R10: A pin reset applied after an overflow returns the status register to 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| pin_rst_n | input | 1 | Asynchronous active-low pin reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| wdt_rst_o | output | 1 | Internal reset pulse, active high |

## Verification
The properties assume that the register port is driven only by the synchronous strobe and that the pin reset stays asserted long enough to pass through the two-stage synchronizer. The bench changes its inputs one time unit after a rising edge and holds `pin_rst_n` low for several cycles. The checks on simultaneous events assume that each rate tick lands exactly one divisor after the previous one. To produce the write-versus-increment and clear-versus-set cases, the bench first sees a counter change at the fastest rate and then times its write to the next tick edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  localparam int unsigned NUM_RATES = 8;

  // Number of low divider bits that must all be 1 for a tick at this rate code.
  function automatic int unsigned tap_width(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 6;
      3'd2:    return 7;
      3'd3:    return 9;
      3'd4:    return 11;
      3'd5:    return 13;
      3'd6:    return 15;
      default: return 17;
    endcase
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int unsigned DIV_W = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [DIV_W-1:0]     div_q, div_d;
  logic [NUM_RATES-1:0] hit;

  always_comb div_d = div_q + DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
    localparam int unsigned K = tap_width(3'(g));
    assign hit[g] = &div_q[K-1:0];
  end

  always_comb tick = run & hit[sel];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active;

  always_comb begin
    active   = run & ~hold;
    wrap_evt = active & ~ld & tick & (&cnt_q);
    cnt_d    = cnt_q;
    if (!active)   cnt_d = '0;
    else if (ld)   cnt_d = ld_val;
    else if (tick) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdog_rstctl.sv
module wdog_rstctl #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic st_we,
  input  logic st_flag_wr,
  input  logic st_arm_wr,
  output logic flag,
  output logic arm,
  output logic pulse,
  output logic trig
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic          flag_q, flag_d;
  logic          arm_q, arm_d;
  logic [PW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    trig   = ovf_evt & arm_q;
    flag_d = flag_q;
    if (ovf_evt)                  flag_d = 1'b1;
    else if (st_we && !st_flag_wr) flag_d = 1'b0;
    arm_d = st_we ? st_arm_wr : arm_q;
    pcnt_d = pcnt_q;
    if (trig)              pcnt_d = PW'(PULSE_LEN);
    else if (pcnt_q != '0) pcnt_d = pcnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign flag  = flag_q;
  assign arm   = arm_q;
  assign pulse = (pcnt_q != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned DIV_W     = 17,
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       pin_rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       wdt_rst_o
);
  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic             en_q, en_d;
  logic [2:0]       sel_q, sel_d;
  logic             tick, wrap_evt, trig;
  logic             flag, arm, pulse;
  logic [CNT_W-1:0] cnt;
  logic             wr_ctrl, wr_cnt, wr_stat;

  always_ff @(posedge clk or negedge pin_rst_n) begin
    if (!pin_rst_n) rs_q <= 2'b00;
    else            rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  always_comb begin
    wr_ctrl = reg_we && (reg_addr == A_CTRL) && !pulse;
    wr_cnt  = reg_we && (reg_addr == A_CNT);
    wr_stat = reg_we && (reg_addr == A_STAT);
  end

  always_comb begin
    en_d  = en_q;
    sel_d = sel_q;
    if (pulse || trig) en_d = 1'b0;
    else if (wr_ctrl)  en_d = reg_wdata[5];
    if (wr_ctrl) sel_d = reg_wdata[2:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q  <= 1'b0;
      sel_q <= 3'd0;
    end else begin
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end

  wdog_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .run  (en_q),
    .sel  (sel_q),
    .tick (tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (en_q),
    .hold    (pulse),
    .tick    (tick),
    .ld      (wr_cnt),
    .ld_val  (reg_wdata[CNT_W-1:0]),
    .cnt     (cnt),
    .wrap_evt(wrap_evt)
  );

  wdog_rstctl #(.PULSE_LEN(PULSE_LEN)) u_rst (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ovf_evt   (wrap_evt),
    .st_we     (wr_stat),
    .st_flag_wr(reg_wdata[7]),
    .st_arm_wr (reg_wdata[6]),
    .flag      (flag),
    .arm       (arm),
    .pulse     (pulse),
    .trig      (trig)
  );

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {2'b00, en_q, 2'b11, sel_q};
      A_CNT:   reg_rdata = 8'(cnt);
      A_STAT:  reg_rdata = {flag, arm, 1'b0, 5'h1F};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign wdt_rst_o = pulse;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PULSE_LEN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             rst_out,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [7:0]       reg_wdata
);
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_run <= '0;
    else if (rst_out) hi_run <= hi_run + 16'd1;
    else              hi_run <= '0;
  end

  p_off_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (cnt == '0));

  p_wrap_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (cnt == '0));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(reg_we && reg_addr == A_STAT && !reg_wdata[7])) |=> flag);

  p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> (hi_run == 16'(PULSE_LEN)));

  p_pulse_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> flag);

  p_wd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> (!en_q && cnt == '0));

  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CNT && en_q && !rst_out)
      |=> (cnt == $past(reg_wdata[CNT_W-1:0])));
endmodule

bind wdog_timer wdog_checker #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .en_q     (en_q),
  .cnt      (cnt),
  .flag     (flag),
  .rst_out  (wdt_rst_o),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam time PER = 10ns;
  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_STAT = 2'd2;

  logic       clk = 1'b0;
  logic       pin_rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       wdt_rst_o;
  logic       rd_req = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #(PER/2) clk = ~clk;

  wdog_timer dut (
    .clk(clk), .pin_rst_n(pin_rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdt_rst_o(wdt_rst_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each read request.
  always @(negedge clk) begin
    if (rd_req) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "scoreboard empty", int'(reg_rdata), 0);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        chk(reg_rdata === it.exp, it.tag, int'(reg_rdata), int'(it.exp));
      end
    end
  end

  task automatic rd_exp(input logic [1:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    rd_req = 1'b1;
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    pin_rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 pin_rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  // Wait at negedges until the watched register reads val.
  task automatic wait_val(input logic [1:0] a, input logic [7:0] val);
    @(posedge clk); #1 reg_addr = a;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (reg_rdata == val) break;
    end
  endtask

  task automatic measure(input logic [2:0] code, input int expd, input string tag);
    logic [7:0] prev;
    int n;
    wr(A_CTRL, {5'b00100, code});
    wr(A_CNT, 8'h00);
    @(posedge clk); #1 reg_addr = A_CNT;
    @(negedge clk); prev = reg_rdata;
    for (int i = 0; i < 140000; i++) begin
      @(negedge clk);
      if (reg_rdata != prev) break;
    end
    prev = reg_rdata;
    n = 0;
    for (int i = 0; i < 140000; i++) begin
      @(negedge clk);
      n++;
      if (reg_rdata != prev) break;
    end
    chk(n == expd, tag, n, expd);
    wr(A_CTRL, 8'h00);
  endtask

  initial begin
    #(PER * 190000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog timeout act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();
    // R1 reset values
    chk(wdt_rst_o == 1'b0, "R1 rst out idle", int'(wdt_rst_o), 0);
    rd_exp(A_CTRL, 8'h18, "R1 ctrl reset");
    rd_exp(A_CNT,  8'h00, "R1 count reset");
    rd_exp(A_STAT, 8'h1F, "R1 status reset");

    // R8 reserved bits
    wr(A_CTRL, 8'hFF);
    rd_exp(A_CTRL, 8'h3F, "R8 ctrl reserved ones");
    wr(A_CTRL, 8'h00);
    rd_exp(A_CTRL, 8'h18, "R8 ctrl reserved stay 1");
    wr(A_STAT, 8'h20);
    rd_exp(A_STAT, 8'h1F, "R8 status reserved");

    // R2 disabled ignores count writes; enable runs; disable zeroes
    wr(A_CNT, 8'h33);
    rd_exp(A_CNT, 8'h00, "R2 write ignored while off");
    wr(A_CTRL, 8'h20);
    repeat (20) @(posedge clk);
    @(negedge clk); reg_addr = A_CNT;
    @(negedge clk);
    chk(reg_rdata != 8'h00, "R2 counting when on", int'(reg_rdata), 1);
    wr(A_CTRL, 8'h00);
    rd_exp(A_CNT, 8'h00, "R2 off zeroes count");
    repeat (10) @(posedge clk);
    rd_exp(A_CNT, 8'h00, "R2 stays stopped");

    // R3 rates
    measure(3'd0, 2,    "R3 rate code 0");
    measure(3'd1, 64,   "R3 rate code 1");
    measure(3'd2, 128,  "R3 rate code 2");
    measure(3'd3, 512,  "R3 rate code 3");
    measure(3'd4, 2048, "R3 rate code 4");
    measure(3'd5, 8192, "R3 rate code 5");

    // R9 plain reload with slow rate
    wr(A_CTRL, 8'h27);
    wr(A_CNT, 8'hA5);
    rd_exp(A_CNT, 8'hA5, "R9 reload");

    // R9 load colliding with a tick
    wr(A_CTRL, 8'h20);
    wr(A_CNT, 8'h10);
    wait_val(A_CNT, 8'h12);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = A_CNT; reg_wdata = 8'h40;
    @(posedge clk); #1 reg_we = 1'b0;
    @(negedge clk);
    chk(reg_rdata == 8'h40, "R9 write beats increment", int'(reg_rdata), 8'h40);

    // R4 wrap sets flag, R6 no pulse when unarmed
    wr(A_CNT, 8'hFC);
    wait_val(A_CNT, 8'hFF);
    @(negedge clk); @(negedge clk);
    chk(reg_rdata == 8'h00, "R4 wrap to zero", int'(reg_rdata), 0);
    chk(wdt_rst_o == 1'b0, "R6 no pulse unarmed", int'(wdt_rst_o), 0);
    rd_exp(A_STAT, 8'h9F, "R4 flag set");

    // R5 write 1 keeps flag, collision keeps flag, write 0 clears
    wr(A_STAT, 8'h80);
    rd_exp(A_STAT, 8'h9F, "R5 write one no effect");
    wr(A_CNT, 8'hF0);
    wait_val(A_CNT, 8'hFF);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = A_STAT; reg_wdata = 8'h00;
    @(posedge clk); #1 reg_we = 1'b0;
    rd_exp(A_STAT, 8'h9F, "R5 set wins over clear");
    wr(A_STAT, 8'h00);
    rd_exp(A_STAT, 8'h1F, "R5 write zero clears");
    wr(A_STAT, 8'h80);
    rd_exp(A_STAT, 8'h1F, "R5 write one does not set");

    // R6/R7 armed overflow
    wr(A_STAT, 8'h40);
    wr(A_CNT, 8'hF8);
    @(posedge clk); #1 reg_addr = A_STAT;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (wdt_rst_o) break;
    end
    chk(wdt_rst_o == 1'b1, "R6 pulse asserted", int'(wdt_rst_o), 1);
    chk(reg_rdata == 8'hDF, "R7 flag with pulse", int'(reg_rdata), 8'hDF);
    n = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!wdt_rst_o) break;
      n++;
    end
    chk(n == 16, "R6 pulse length", n, 16);
    rd_exp(A_CTRL, 8'h18, "R7 enable cleared");
    rd_exp(A_CNT,  8'h00, "R7 count cleared");
    rd_exp(A_STAT, 8'hDF, "R7 status kept");

    // R10 pin reset restores status
    do_reset();
    rd_exp(A_STAT, 8'h1F, "R10 status after pin reset");
    rd_exp(A_CTRL, 8'h18, "R10 ctrl after pin reset");

    repeat (3) @(posedge clk);
    chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule